// File: doc/BRIEF.md
# Channel-Masked Shadow Register Bank

This block holds the control registers of a four-channel synthesizer. A deserializing front end delivers bytes on a valid/ready stream. The first byte of each transaction is a register address. A fixed number of data bytes follows, and that number depends on the address. Multi-byte values are assembled most significant byte first. A global control byte sets three things: which channel copies receive writes to channel-scoped addresses, the serial mode reported back to the front end, and the bit order of incoming data bytes.

Most registers are double-buffered. A write fills a buffer, and a one-cycle update pulse copies every buffer into its active register. This happens in the global function register and in every channel at once. The control byte is not buffered and acts as soon as its byte is accepted. The active function register drives a loop-enable flag, which is decoded from a 5-bit multiplier field. Readback shows the active channel values of the lowest-numbered enabled channel.

The stream applies no back-pressure. `s_ready` is held high, and every cycle with `s_valid` high consumes one byte. A source may still wait on `s_ready` without harm.

Top module: `chan_shadow_regbank`

## Requirements
- R1: Every byte offered with `s_valid` is accepted, and `s_ready` is always 1. The first byte of a transaction is an address, and a fixed number of data bytes follows it: 0x00 takes 1, 0x01 takes 3, 0x04 takes 4 and 0x05 takes 2. Multi-byte values are loaded most significant byte first.
- R2: After reset the control byte is 0xF0, every buffer and active register is 0, `pll_en` is 0 and both error flags are 0.
- R3: In the control byte (address 0x00), bit 4+n enables channel n. A new mask takes effect in the cycle after its byte is accepted, without any update pulse.
- R4: A write to 0x04 (32-bit tuning word) or to 0x05 (16-bit phase word) loads the buffer of every enabled channel. A disabled channel's buffer is left unchanged.
- R5: A one-cycle `upd` pulse copies the function-register buffer and the buffers of every channel into their active registers. Without the pulse, the active values do not change.
- R6: `rd_ftw` and `rd_phase` show the active values of the lowest-numbered enabled channel. They are 0 when no channel is enabled.
- R7: Control bits 2:1 give the serial mode (00 two-wire single-bit, 01 three-wire single-bit, 10 two-bit, 11 four-bit). These bits appear on `csr_o[2:1]`.
- R8: When control bit 0 is 1, each data byte is bit-reversed (bit i goes to bit 7-i) before assembly. Address bytes are never reversed.
- R9: Writing control bit 3 as 1 stores it as 0 and sets the sticky flag `err_rsv`.
- R10: `pll_en` is 1 only when bits 22:18 of the active function register hold a value from 4 to 20 inclusive.
- R11: An address other than 0x00, 0x01, 0x04 or 0x05 writes nothing and sets the sticky flag `err_addr`. The next byte is then taken as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Byte on `s_data` is valid |
| s_ready | output | 1 | Always 1; no back-pressure |
| s_data | input | 8 | Incoming address or data byte |
| upd | input | 1 | One-cycle buffer-to-active copy strobe |
| csr_o | output | 8 | Current control byte (mask, mode, bit order) |
| fr1_o | output | 24 | Active function register |
| pll_en | output | 1 | Loop enable decoded from multiplier field |
| rd_ftw | output | 32 | Active tuning word of lowest enabled channel |
| rd_phase | output | 16 | Active phase word of lowest enabled channel |
| err_rsv | output | 1 | Sticky: reserved control bit written as 1 |
| err_addr | output | 1 | Sticky: unknown address seen |

## Verification
The assertions check, on every cycle, the hold behaviour of the bank. The control byte can change only after an accepted byte. The active function register and `pll_en` can change only after an update pulse. Readback stays put when neither a byte nor an update arrives, and both error flags never clear. The bench scenarios show the values themselves: which channel copies a masked broadcast reached, byte assembly order and bit reversal, the multiplier range edges at 3, 4, 20 and 21, and recovery after an unknown address.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int ADDR_W  = 8;
  localparam int BYTE_W  = 8;
  localparam int FTW_W   = 32;
  localparam int PH_W    = 16;
  localparam int FR1_W   = 24;
  localparam int WORD_W  = FTW_W;
  localparam int LEN_W   = 3;
  localparam int MUL_LSB = 18;
  localparam int MUL_W   = 5;
  localparam int PLL_MIN = 4;
  localparam int PLL_MAX = 20;
  localparam int EN_LSB  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_FUNC = 8'h01;
  localparam logic [ADDR_W-1:0] A_TUNE = 8'h04;
  localparam logic [ADDR_W-1:0] A_PHAS = 8'h05;

  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hF0;

  function automatic logic [LEN_W-1:0] addr_len(input logic [ADDR_W-1:0] a);
    case (a)
      A_CTRL:  addr_len = LEN_W'(1);
      A_FUNC:  addr_len = LEN_W'(FR1_W / BYTE_W);
      A_TUNE:  addr_len = LEN_W'(FTW_W / BYTE_W);
      A_PHAS:  addr_len = LEN_W'(PH_W / BYTE_W);
      default: addr_len = '0;
    endcase
  endfunction

  function automatic logic is_chan_addr(input logic [ADDR_W-1:0] a);
    is_chan_addr = (a == A_TUNE) || (a == A_PHAS);
  endfunction

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    for (int i = 0; i < BYTE_W; i++) rev_byte[i] = b[BYTE_W-1-i];
  endfunction
endpackage

// File: rtl/rb_byte_parser.sv
module rb_byte_parser
  import rb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_fire,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic                lsb_first,
  output logic                commit_o,
  output logic [ADDR_W-1:0]   commit_addr_o,
  output logic [WORD_W-1:0]   commit_data_o,
  output logic                bad_addr_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [WORD_W-1:0] acc_q;
  logic [BYTE_W-1:0] byte_ord;
  logic [WORD_W-1:0] acc_nxt;
  logic [LEN_W-1:0]  new_len;

  // Address bytes are taken as sent; only data bytes follow the order flag.
  assign byte_ord = lsb_first ? rev_byte(in_byte) : in_byte;
  assign acc_nxt  = {acc_q[WORD_W-BYTE_W-1:0], byte_ord};
  assign new_len  = addr_len(in_byte);

  assign commit_o      = in_fire && busy_q && (left_q == LEN_W'(1));
  assign commit_addr_o = addr_q;
  assign commit_data_o = acc_nxt;
  assign bad_addr_o    = in_fire && !busy_q && (new_len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      acc_q  <= '0;
    end else if (in_fire) begin
      if (!busy_q) begin
        if (new_len != '0) begin
          busy_q <= 1'b1;
          addr_q <= in_byte;
          left_q <= new_len;
          acc_q  <= '0;
        end
      end else begin
        acc_q  <= acc_nxt;
        left_q <= left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rb_global_regs.sv
module rb_global_regs
  import rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [ADDR_W-1:0]  commit_addr,
  input  logic [WORD_W-1:0]  commit_data,
  input  logic               bad_addr,
  input  logic               upd,
  output logic [BYTE_W-1:0]  ctrl_o,
  output logic [FR1_W-1:0]   func_act_o,
  output logic               pll_en_o,
  output logic               err_rsv_o,
  output logic               err_addr_o
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [FR1_W-1:0]  func_buf_q;
  logic [FR1_W-1:0]  func_act_q;
  logic              err_rsv_q;
  logic              err_addr_q;
  logic [MUL_W-1:0]  mul_fld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RESET;
      func_buf_q <= '0;
      func_act_q <= '0;
      err_rsv_q  <= 1'b0;
      err_addr_q <= 1'b0;
    end else begin
      if (commit && commit_addr == A_CTRL) begin
        ctrl_q <= {commit_data[7:4], 1'b0, commit_data[2:0]};
        if (commit_data[3]) err_rsv_q <= 1'b1;
      end
      if (commit && commit_addr == A_FUNC) func_buf_q <= commit_data[FR1_W-1:0];
      if (upd) func_act_q <= func_buf_q;
      if (bad_addr) err_addr_q <= 1'b1;
    end
  end

  assign mul_fld    = func_act_q[MUL_LSB +: MUL_W];
  assign pll_en_o   = (mul_fld >= MUL_W'(PLL_MIN)) && (mul_fld <= MUL_W'(PLL_MAX));
  assign ctrl_o     = ctrl_q;
  assign func_act_o = func_act_q;
  assign err_rsv_o  = err_rsv_q;
  assign err_addr_o = err_addr_q;
endmodule

// File: rtl/rb_chan_slot.sv
module rb_chan_slot
  import rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               upd,
  output logic [FTW_W-1:0]   ftw_act_o,
  output logic [PH_W-1:0]    ph_act_o
);
  logic [FTW_W-1:0] ftw_buf_q, ftw_act_q;
  logic [PH_W-1:0]  ph_buf_q,  ph_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_buf_q <= '0;
      ftw_act_q <= '0;
      ph_buf_q  <= '0;
      ph_act_q  <= '0;
    end else begin
      if (wr_en && wr_addr == A_TUNE) ftw_buf_q <= wr_data[FTW_W-1:0];
      if (wr_en && wr_addr == A_PHAS) ph_buf_q  <= wr_data[PH_W-1:0];
      if (upd) begin
        ftw_act_q <= ftw_buf_q;
        ph_act_q  <= ph_buf_q;
      end
    end
  end

  assign ftw_act_o = ftw_act_q;
  assign ph_act_o  = ph_act_q;
endmodule

// File: rtl/chan_shadow_regbank.sv
module chan_shadow_regbank
  import rb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [BYTE_W-1:0]   s_data,
  input  logic                upd,
  output logic [BYTE_W-1:0]   csr_o,
  output logic [FR1_W-1:0]    fr1_o,
  output logic                pll_en,
  output logic [FTW_W-1:0]    rd_ftw,
  output logic [PH_W-1:0]     rd_phase,
  output logic                err_rsv,
  output logic                err_addr
);
  logic              fire;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_data;
  logic              bad_addr;
  logic [NUM_CH-1:0] ch_en;
  logic [FTW_W-1:0]  ftw_act [NUM_CH];
  logic [PH_W-1:0]   ph_act  [NUM_CH];

  assign s_ready = 1'b1;
  assign fire    = s_valid && s_ready;
  assign ch_en   = csr_o[EN_LSB +: NUM_CH];

  rb_byte_parser u_parser (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_fire       (fire),
    .in_byte       (s_data),
    .lsb_first     (csr_o[0]),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data),
    .bad_addr_o    (bad_addr)
  );

  rb_global_regs u_glob (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .bad_addr    (bad_addr),
    .upd         (upd),
    .ctrl_o      (csr_o),
    .func_act_o  (fr1_o),
    .pll_en_o    (pll_en),
    .err_rsv_o   (err_rsv),
    .err_addr_o  (err_addr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic slot_wr;
    assign slot_wr = commit && ch_en[ch] && is_chan_addr(commit_addr);
    rb_chan_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (slot_wr),
      .wr_addr   (commit_addr),
      .wr_data   (commit_data),
      .upd       (upd),
      .ftw_act_o (ftw_act[ch]),
      .ph_act_o  (ph_act[ch])
    );
  end

  // Lowest-numbered enabled channel wins: scan downward, last hit stays.
  always_comb begin
    rd_ftw   = '0;
    rd_phase = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ch_en[i]) begin
        rd_ftw   = ftw_act[i];
        rd_phase = ph_act[i];
      end
    end
  end
endmodule

// File: rtl/chan_shadow_regbank_chk.sv
module chan_shadow_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        upd,
  input logic [7:0]  csr_o,
  input logic [23:0] fr1_o,
  input logic        pll_en,
  input logic [31:0] rd_ftw,
  input logic        err_rsv,
  input logic        err_addr
);
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(csr_o));

  assert_func_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(fr1_o));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready) && !upd) |=> $stable(rd_ftw));

  assert_rsv_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_rsv |=> err_rsv);

  assert_pll_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(pll_en));

  assert_addr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr |=> err_addr);
endmodule

bind chan_shadow_regbank chan_shadow_regbank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .upd      (upd),
  .csr_o    (csr_o),
  .fr1_o    (fr1_o),
  .pll_en   (pll_en),
  .rd_ftw   (rd_ftw),
  .err_rsv  (err_rsv),
  .err_addr (err_addr)
);

// File: tb/chan_shadow_regbank_tb.sv
module chan_shadow_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = 8'h00;
  logic        upd = 1'b0;
  logic [7:0]  csr_o;
  logic [23:0] fr1_o;
  logic        pll_en;
  logic [31:0] rd_ftw;
  logic [15:0] rd_phase;
  logic        err_rsv;
  logic        err_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  chan_shadow_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .upd(upd), .csr_o(csr_o), .fr1_o(fr1_o),
    .pll_en(pll_en), .rd_ftw(rd_ftw), .rd_phase(rd_phase),
    .err_rsv(err_rsv), .err_addr(err_addr)
  );

  // {channel mask, tuning word}
  localparam logic [35:0] VEC [4] = '{
    {4'b1001, 32'h1234_5678},
    {4'b0010, 32'hCAFE_F00D},
    {4'b1111, 32'h0BAD_BEEF},
    {4'b0110, 32'h7654_3210}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = b;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] b);
    send(8'h00);
    send(b);
  endtask

  task automatic wr_tune(input logic [31:0] v);
    send(8'h04);
    for (int k = 3; k >= 0; k--) send(v[k*8 +: 8]);
  endtask

  task automatic wr_func(input logic [23:0] v);
    send(8'h01);
    for (int k = 2; k >= 0; k--) send(v[k*8 +: 8]);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state, R1 ready
    check("R2 ctrl", {24'h0, csr_o}, 32'hF0);
    check("R2 func", {8'h0, fr1_o}, 32'h0);
    check("R2 tune", rd_ftw, 32'h0);
    check("R2 flags", {29'h0, pll_en, err_rsv, err_addr}, 32'h0);
    check("R1 ready", {31'h0, s_ready}, 32'h1);

    // R4 broadcast under masks, R3 immediate mask, R6 readback, R1 byte order
    for (int i = 0; i < 4; i++) begin
      logic [3:0]  m;
      logic [31:0] v, bg;
      m  = VEC[i][35:32];
      v  = VEC[i][31:0];
      bg = 32'hA5A5_0000 | i;
      wr_ctrl(8'hF0);
      wr_tune(bg);
      wr_ctrl({m, 4'h0});
      wr_tune(v);
      pulse_upd();
      for (int n = 0; n < 4; n++) begin
        wr_ctrl(8'h10 << n);
        check("R4 R3 R6 channel copy", rd_ftw, m[n] ? v : bg);
      end
    end

    wr_ctrl(8'h00);
    check("R6 no channel enabled", rd_ftw, 32'h0);

    // R5 gating: buffer written, active unchanged until upd
    wr_ctrl(8'hF0);
    wr_tune(32'h1122_3344);
    check("R5 before update", rd_ftw, 32'hA5A5_0003);
    pulse_upd();
    check("R5 after update", rd_ftw, 32'h1122_3344);

    // R7 serial mode
    wr_ctrl(8'hF6);
    check("R7 mode", {30'h0, csr_o[2:1]}, 32'h3);
    wr_ctrl(8'hF0);

    // R8 bit reversal of data bytes
    wr_ctrl(8'hF1);
    check("R8 order flag", {24'h0, csr_o}, 32'hF1);
    send(8'h05); send(8'h01); send(8'h80);
    pulse_upd();
    check("R8 reversed phase", {16'h0, rd_phase}, 32'h8001);
    wr_ctrl(8'h0F);
    check("R8 reversed ctrl byte", {24'h0, csr_o}, 32'hF0);

    // R9 reserved bit
    wr_ctrl(8'hF8);
    check("R9 stored zero", {24'h0, csr_o}, 32'hF0);
    check("R9 flag", {31'h0, err_rsv}, 32'h1);
    wr_ctrl(8'hF0);
    check("R9 sticky", {31'h0, err_rsv}, 32'h1);

    // R10 multiplier range edges
    wr_func(24'd3 << 18);
    pulse_upd();
    check("R10 mult 3", {31'h0, pll_en}, 32'h0);
    wr_func(24'd4 << 18);
    check("R10 R5 mult 4 before update", {31'h0, pll_en}, 32'h0);
    pulse_upd();
    check("R10 mult 4", {31'h0, pll_en}, 32'h1);
    check("R10 func value", {8'h0, fr1_o}, 32'h0010_0000);
    wr_func(24'd20 << 18);
    pulse_upd();
    check("R10 mult 20", {31'h0, pll_en}, 32'h1);
    wr_func(24'd21 << 18);
    pulse_upd();
    check("R10 mult 21", {31'h0, pll_en}, 32'h0);

    // R11 unknown address
    check("R11 flag clear", {31'h0, err_addr}, 32'h0);
    send(8'h07);
    check("R11 flag set", {31'h0, err_addr}, 32'h1);
    send(8'h05); send(8'h12); send(8'h34);
    pulse_upd();
    check("R11 next byte is address", {16'h0, rd_phase}, 32'h1234);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule